// File: doc/BRIEF.md
# DAC Startup and Resynchronization Sequencer

This controller takes a high-speed digital-to-analog converter from reset to live transmission and brings it back after a fault. It holds the converter's transmit enable low for the whole bring-up. It then writes the complete configuration register space through a simple valid/ready write port. After that it arms the FIFO-pointer and clock-divider sync enables and asks the data source for a sync pulse. Once a programmable settle window has passed, it trims the sync enables to suit the chosen sync topology and only then raises transmit enable.

The sequencer keeps its own shadow copies of the three sync-related registers: the FIFO sync register at address 0x00, the divider sync register at 0x12 and the source-select register at 0x13. Every sync write is a read-modify-write of a shadow, so the unrelated bits of those registers survive. A lost clock or a FIFO collision reported during the settle window or during transmission drops transmit enable and restarts the flow at the sync setup step. The bulk register load is not repeated. A saturating counter records how many such restarts have taken place.

Top module: `dac_sync_seq`

## Requirements
- R1: While reset is held, and until `start` is seen, txEnable, wrValid, syncReq, busy and done are all 0 and faultCount is 0. The shadows reset to 0x70 (address 0x00), 0x02 (address 0x12) and 0x00 (address 0x13).
- R2: A `start` pulse while idle launches one write to every address from 0 up to REG_NUM-1 (default 32), in ascending order. Addresses 0x00, 0x12 and 0x13 carry their shadow value and every other address carries FILL (default 0x00).
- R3: wrValid, once raised, holds with wrAddr and wrData stable until a cycle in which wrReady is 1. Each cycle with wrValid and wrReady both 1 completes exactly one write.
- R4: After the last bulk write, three sync setup writes follow, in this order. First, 0x00 with bits 5 and 4 set. Second, 0x13 with bit 1 equal to dualSync. Third, 0x12 with bit 1 set. All other bits come from the shadow.
- R5: When the third setup write completes, a settle window of waitCycles+1 cycles begins. syncReq is 1 in the first cycle of the window. Unless R6 applies, this is its only high cycle in the window, which gives exactly one rising edge.
- R6: With dualSync=1 and periodicSync=1, syncReq is also 1 for a single cycle every SYNC_PERIOD (default 8) cycles of the window. With dualSync=0, periodicSync has no effect.
- R7: At the end of the window with dualSync=0, a write to 0x12 with bit 1 cleared follows. With dualSync=1, no write to 0x12 follows.
- R8: With fifoLock=1 at the end of the window, a write to 0x00 with bits 5 and 4 cleared follows, after the 0x12 write of R7 if there is one.
- R9: txEnable and done are 1 only in the active state. The active state begins in the cycle after the last trim write completes, or after the window ends when there is no trim write. busy is 1 while writing or settling after start, and no write is in flight while txEnable is 1.
- R10: clkLost or fifoCollision during the window or while active has three effects. It drops txEnable in the next cycle, it adds 1 to faultCount (saturating), and it restarts at the R4 writes without repeating the R2 writes.
- R11: clkLost and fifoCollision have no effect while a write sequence is in progress. faultCount is unchanged and the writes carry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the bring-up when idle |
| dualSync | input | 1 | 1: two sync sources, 0: one sync source |
| periodicSync | input | 1 | Periodic sync request (two-source mode only) |
| fifoLock | input | 1 | Clear FIFO sync enables after the window |
| waitCycles | input | WAIT_W | Settle window length minus one |
| clkLost | input | 1 | Data or converter clock lost |
| fifoCollision | input | 1 | FIFO pointer collision alarm |
| wrReady | input | 1 | Write port ready |
| wrValid | output | 1 | Write request valid |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | DATA_W | Write data |
| syncReq | output | 1 | Sync pulse request to the data source |
| txEnable | output | 1 | Converter transmit enable |
| busy | output | 1 | Writing or settling |
| done | output | 1 | Sequence complete, transmitting |
| faultCount | output | FAULT_W | Saturating restart count |

## Verification
The assertions assume three things about the inputs. The mode inputs dualSync, periodicSync and fifoLock do not change while a write sequence or settle window is under way. `start` matters only in the idle state. wrReady may stall for any number of cycles. The stimulus follows these rules by changing modes only while txEnable is high and in cycles with no fault. It stalls wrReady with a repeating pattern so that held requests are exercised. It raises faults only for single cycles, placed inside a write sequence, inside a settle window and during transmission.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Register addresses the converter decodes; the sequencer's behaviour depends on them.
  localparam int FIFO_REG_ADDR = 'h00;
  localparam int DIV_REG_ADDR  = 'h12;
  localparam int SRC_REG_ADDR  = 'h13;

  // Bit masks inside those registers.
  localparam int FIFO_SYNC_MASK = 'h30;  // write and read pointer sync enables
  localparam int DIV_SYNC_MASK  = 'h02;  // clock divider sync enable
  localparam int SRC_SEL_MASK   = 'h02;  // sync source select

  // Shadow reset values.
  localparam int FIFO_REG_INIT = 'h70;
  localparam int DIV_REG_INIT  = 'h02;
  localparam int SRC_REG_INIT  = 'h00;

  typedef enum logic [2:0] {
    OP_BULK,
    OP_SET_FIFO,
    OP_SEL_SRC,
    OP_SET_DIV,
    OP_CLR_DIV,
    OP_CLR_FIFO
  } wrOp_t;

  typedef struct packed {
    logic  issue;      // load a new write request
    wrOp_t op;         // which write to load
    logic  settle;     // settle window running
    logic  bumpFault;  // count one restart
  } seqStrobe_t;

endpackage

// File: rtl/dss_dpath.sv
module dss_dpath
  import dss_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int REG_NUM     = 32,
  parameter int WAIT_W      = 8,
  parameter int SYNC_PERIOD = 8,
  parameter int FILL        = 0,
  parameter int FAULT_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               dualSync,
  input  logic               periodicSync,
  input  logic [WAIT_W-1:0]  waitCycles,
  input  logic               wrReady,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic               wrAck,
  output logic               bulkLast,
  output logic               settleDone,
  output logic               syncReq,
  output logic [FAULT_W-1:0] faultCount
);

  localparam int PER_W = $clog2(SYNC_PERIOD);
  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(FIFO_REG_ADDR);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DIV_REG_ADDR);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(SRC_REG_ADDR);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(REG_NUM - 1);
  localparam logic [DATA_W-1:0] M_FIFO = DATA_W'(FIFO_SYNC_MASK);
  localparam logic [DATA_W-1:0] M_DIV  = DATA_W'(DIV_SYNC_MASK);
  localparam logic [DATA_W-1:0] M_SRC  = DATA_W'(SRC_SEL_MASK);

  logic [DATA_W-1:0] shFifo, shDiv, shSrc;
  logic [ADDR_W-1:0] bulkIdx;
  logic [WAIT_W-1:0] timer;
  logic [ADDR_W-1:0] nextAddr;
  logic [DATA_W-1:0] nextData;
  logic              perHit;

  // Address and read-modify-write data for the requested write.
  always_comb begin
    nextAddr = bulkIdx;
    nextData = DATA_W'(FILL);
    unique case (strb.op)
      OP_BULK: begin
        nextAddr = bulkIdx;
        if (bulkIdx == A_FIFO)     nextData = shFifo;
        else if (bulkIdx == A_DIV) nextData = shDiv;
        else if (bulkIdx == A_SRC) nextData = shSrc;
        else                       nextData = DATA_W'(FILL);
      end
      OP_SET_FIFO: begin nextAddr = A_FIFO; nextData = shFifo | M_FIFO;  end
      OP_CLR_FIFO: begin nextAddr = A_FIFO; nextData = shFifo & ~M_FIFO; end
      OP_SEL_SRC: begin
        nextAddr = A_SRC;
        nextData = dualSync ? (shSrc | M_SRC) : (shSrc & ~M_SRC);
      end
      OP_SET_DIV:  begin nextAddr = A_DIV; nextData = shDiv | M_DIV;  end
      OP_CLR_DIV:  begin nextAddr = A_DIV; nextData = shDiv & ~M_DIV; end
      default:     begin nextAddr = bulkIdx; nextData = DATA_W'(FILL); end
    endcase
  end

  // Write port and shadows.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      bulkIdx <= '0;
      shFifo  <= DATA_W'(FIFO_REG_INIT);
      shDiv   <= DATA_W'(DIV_REG_INIT);
      shSrc   <= DATA_W'(SRC_REG_INIT);
    end else if (strb.issue) begin
      wrValid <= 1'b1;
      wrAddr  <= nextAddr;
      wrData  <= nextData;
      unique case (strb.op)
        OP_BULK:                 bulkIdx <= bulkIdx + 1'b1;
        OP_SET_FIFO, OP_CLR_FIFO: shFifo <= nextData;
        OP_SEL_SRC:              shSrc  <= nextData;
        OP_SET_DIV, OP_CLR_DIV:  shDiv  <= nextData;
        default:                 bulkIdx <= bulkIdx;
      endcase
    end else if (wrAck) begin
      wrValid <= 1'b0;
    end
  end

  // Settle timer and restart counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer      <= '0;
      faultCount <= '0;
    end else begin
      timer <= strb.settle ? timer + 1'b1 : '0;
      if (strb.bumpFault && faultCount != '1)
        faultCount <= faultCount + 1'b1;
    end
  end

  generate
    if (PER_W == 0) begin : gPerAll
      assign perHit = 1'b1;
    end else begin : gPerMod
      assign perHit = (timer[PER_W-1:0] == '0);
    end
  endgenerate

  assign wrAck      = wrValid & wrReady;
  assign bulkLast   = (wrAddr == A_LAST);
  assign settleDone = (timer == waitCycles);
  assign syncReq    = strb.settle &&
                      ((timer == '0) || (dualSync && periodicSync && perHit));

endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dualSync,
  input  logic       fifoLock,
  input  logic       clkLost,
  input  logic       fifoCollision,
  input  logic       wrAck,
  input  logic       bulkLast,
  input  logic       settleDone,
  output seqStrobe_t strb,
  output logic       txEnable,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_SETTLE, S_ACTIVE} seqState_t;

  seqState_t state, nextState;
  wrOp_t     opCur, nextOp;
  logic      doIssue;
  wrOp_t     issueOp;
  logic      fault;

  assign fault = clkLost | fifoCollision;

  always_comb begin
    nextState      = state;
    doIssue        = 1'b0;
    issueOp        = OP_BULK;
    strb           = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          doIssue = 1'b1; issueOp = OP_BULK; nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        if (wrAck) begin
          unique case (opCur)
            OP_BULK: begin
              doIssue = 1'b1;
              issueOp = bulkLast ? OP_SET_FIFO : OP_BULK;
            end
            OP_SET_FIFO: begin doIssue = 1'b1; issueOp = OP_SEL_SRC; end
            OP_SEL_SRC:  begin doIssue = 1'b1; issueOp = OP_SET_DIV; end
            OP_SET_DIV:  nextState = S_SETTLE;
            OP_CLR_DIV: begin
              if (fifoLock) begin doIssue = 1'b1; issueOp = OP_CLR_FIFO; end
              else nextState = S_ACTIVE;
            end
            OP_CLR_FIFO: nextState = S_ACTIVE;
            default:     nextState = S_ACTIVE;
          endcase
        end
      end
      S_SETTLE: begin
        strb.settle = 1'b1;
        if (fault) begin
          strb.bumpFault = 1'b1;
          doIssue = 1'b1; issueOp = OP_SET_FIFO; nextState = S_WRITE;
        end else if (settleDone) begin
          if (!dualSync) begin
            doIssue = 1'b1; issueOp = OP_CLR_DIV; nextState = S_WRITE;
          end else if (fifoLock) begin
            doIssue = 1'b1; issueOp = OP_CLR_FIFO; nextState = S_WRITE;
          end else begin
            nextState = S_ACTIVE;
          end
        end
      end
      S_ACTIVE: begin
        if (fault) begin
          strb.bumpFault = 1'b1;
          doIssue = 1'b1; issueOp = OP_SET_FIFO; nextState = S_WRITE;
        end
      end
      default: nextState = S_IDLE;
    endcase
    strb.issue = doIssue;
    strb.op    = issueOp;
    nextOp     = doIssue ? issueOp : opCur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opCur <= OP_BULK;
    end else begin
      state <= nextState;
      opCur <= nextOp;
    end
  end

  assign txEnable = (state == S_ACTIVE);
  assign done     = (state == S_ACTIVE);
  assign busy     = (state == S_WRITE) || (state == S_SETTLE);

endmodule

// File: rtl/dac_sync_seq.sv
module dac_sync_seq
  import dss_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int REG_NUM     = 32,
  parameter int WAIT_W      = 8,
  parameter int SYNC_PERIOD = 8,
  parameter int FILL        = 0,
  parameter int FAULT_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               dualSync,
  input  logic               periodicSync,
  input  logic               fifoLock,
  input  logic [WAIT_W-1:0]  waitCycles,
  input  logic               clkLost,
  input  logic               fifoCollision,
  input  logic               wrReady,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic               syncReq,
  output logic               txEnable,
  output logic               busy,
  output logic               done,
  output logic [FAULT_W-1:0] faultCount
);

  seqStrobe_t strb;
  logic       wrAck, bulkLast, settleDone;

  dss_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .dualSync(dualSync),
    .fifoLock(fifoLock), .clkLost(clkLost), .fifoCollision(fifoCollision),
    .wrAck(wrAck), .bulkLast(bulkLast), .settleDone(settleDone),
    .strb(strb), .txEnable(txEnable), .busy(busy), .done(done)
  );

  dss_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_NUM(REG_NUM), .WAIT_W(WAIT_W),
    .SYNC_PERIOD(SYNC_PERIOD), .FILL(FILL), .FAULT_W(FAULT_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dualSync(dualSync),
    .periodicSync(periodicSync), .waitCycles(waitCycles), .wrReady(wrReady),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck),
    .bulkLast(bulkLast), .settleDone(settleDone), .syncReq(syncReq),
    .faultCount(faultCount)
  );

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  parameter int FAULT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               clkLost,
  input logic               fifoCollision,
  input logic               wrReady,
  input logic               wrValid,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic               syncReq,
  input logic               txEnable,
  input logic               busy,
  input logic [FAULT_W-1:0] faultCount
);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    txEnable |-> (!wrValid && !busy));

  assert_sync_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |-> (busy && !wrValid && !txEnable));

  assert_fault_drops_tx_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && (clkLost || fifoCollision)) |=> !txEnable);

  assert_fault_counted_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && (clkLost || fifoCollision) && faultCount != '1)
      |=> faultCount == $past(faultCount) + FAULT_W'(1));

  assert_fault_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && (clkLost || fifoCollision)) |=> $stable(faultCount));

endmodule

bind dac_sync_seq dss_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAULT_W(FAULT_W)
) uChecker (
  .clk(clk), .rstN(rstN), .clkLost(clkLost), .fifoCollision(fifoCollision),
  .wrReady(wrReady), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
  .syncReq(syncReq), .txEnable(txEnable), .busy(busy), .faultCount(faultCount)
);

// File: tb/dac_sync_seq_test.sv
`timescale 1ns/1ps
module dac_sync_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0, dualSync = 1'b0, periodicSync = 1'b0, fifoLock = 1'b0;
  logic [7:0] waitCycles = 8'd5;
  logic       clkLost = 1'b0, fifoCollision = 1'b0, wrReady = 1'b0;
  logic       wrValid, syncReq, txEnable, busy, done;
  logic [6:0] wrAddr;
  logic [7:0] wrData;
  logic [7:0] faultCount;

  int tests = 0, fails = 0, cyc = 0;
  bit stallOn = 1'b1;

  always #4 clk = ~clk;

  dac_sync_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .dualSync(dualSync),
    .periodicSync(periodicSync), .fifoLock(fifoLock), .waitCycles(waitCycles),
    .clkLost(clkLost), .fifoCollision(fifoCollision), .wrReady(wrReady),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .syncReq(syncReq),
    .txEnable(txEnable), .busy(busy), .done(done), .faultCount(faultCount)
  );

  // Behavioural reference: phase 0 idle, 1 writing, 2 settling, 3 active.
  int    phase = 0, afterW = 2, cnt = 0, mFaults = 0;
  int    sh [0:127];
  int    addrQ[$], dataQ[$];
  string tagQ[$];
  int    addr1Writes = 0;

  task automatic pushW(int a, int d, string t);
    addrQ.push_back(a); dataQ.push_back(d); tagQ.push_back(t);
  endtask

  task automatic pushSetup();
    sh['h00] = sh['h00] | 'h30;                       pushW('h00, sh['h00], "R4");
    sh['h13] = dualSync ? (sh['h13] | 2) : (sh['h13] & ~2); pushW('h13, sh['h13], "R4");
    sh['h12] = sh['h12] | 2;                          pushW('h12, sh['h12], "R4");
  endtask

  task automatic pushTrims();
    if (!dualSync) begin sh['h12] = sh['h12] & ~2; pushW('h12, sh['h12], "R7"); end
    if (fifoLock)  begin sh['h00] = sh['h00] & ~'h30; pushW('h00, sh['h00], "R8"); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (wrValid && wrReady && wrAddr == 7'd1) addr1Writes++;
    if (!rstN) begin
      phase = 0; cnt = 0; mFaults = 0;
      addrQ.delete(); dataQ.delete(); tagQ.delete();
      for (int i = 0; i < 128; i++) sh[i] = 0;
      sh['h00] = 'h70; sh['h12] = 'h02; sh['h13] = 'h00;
    end else begin
      case (phase)
        0: if (start) begin
             for (int a = 0; a < 32; a++) pushW(a, sh[a], "R2");
             pushSetup(); phase = 1; afterW = 2;
           end
        1: if (wrReady) begin
             void'(addrQ.pop_front()); void'(dataQ.pop_front()); void'(tagQ.pop_front());
             if (addrQ.size() == 0) begin
               if (afterW == 2) begin phase = 2; cnt = 0; end else phase = 3;
             end
           end
        2: if (clkLost || fifoCollision) begin
             mFaults++; pushSetup(); phase = 1; afterW = 2;
           end else if (cnt == int'(waitCycles)) begin
             pushTrims();
             if (addrQ.size() == 0) phase = 3; else begin phase = 1; afterW = 3; end
           end else cnt++;
        3: if (clkLost || fifoCollision) begin
             mFaults++; pushSetup(); phase = 1; afterW = 2;
           end
        default: phase = 0;
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Compare every cycle, away from the edge.
  always @(posedge clk) begin
    #2;
    if (!rstN) begin
      chk("R1", txEnable, 0); chk("R1", wrValid, 0); chk("R1", syncReq, 0);
      chk("R1", busy, 0); chk("R1", done, 0); chk("R1", faultCount, 0);
    end else begin
      chk("R3", wrValid, phase == 1);
      if (phase == 1 && wrValid) begin
        chk(tagQ[0], wrAddr, addrQ[0]);
        chk(tagQ[0], wrData, dataQ[0]);
      end
      chk((dualSync && periodicSync) ? "R6" : "R5", syncReq,
          phase == 2 && (cnt == 0 || (dualSync && periodicSync && cnt % 8 == 0)));
      chk("R9", txEnable, phase == 3);
      chk("R9", done, phase == 3);
      chk("R9", busy, phase == 1 || phase == 2);
      chk("R10", faultCount, mFaults);
    end
  end

  // Ready pattern, driven away from the edge.
  always @(negedge clk) wrReady <= stallOn ? (cyc % 3 != 1) : 1'b1;

  task automatic waitTx();
    int guard = 0;
    while (!txEnable && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) begin fails++; tests++; $display("FAIL R9: txEnable never rose actual 0 expected 1"); end
  endtask

  task automatic pulseFault(bit which);
    @(negedge clk);
    if (which) clkLost = 1'b1; else fifoCollision = 1'b1;
    @(negedge clk);
    clkLost = 1'b0; fifoCollision = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // Single source, periodic requested but must be ignored, lock on.
    dualSync = 1'b0; periodicSync = 1'b1; fifoLock = 1'b1; waitCycles = 8'd5;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitTx();
    repeat (4) @(negedge clk);
    chk("R2", addr1Writes, 1);
    // Clock loss while active: resync without bulk load.
    pulseFault(1'b1);
    waitTx();
    chk("R10", faultCount, 1);
    chk("R10", addr1Writes, 1);
    // Dual source, periodic, no lock, long window.
    dualSync = 1'b1; periodicSync = 1'b1; fifoLock = 1'b0; waitCycles = 8'd20;
    repeat (2) @(negedge clk);
    pulseFault(1'b0);
    // Fault in the middle of the write sequence: ignored.
    clkLost = 1'b1; @(negedge clk); clkLost = 1'b0;
    chk("R11", faultCount, 2);
    waitTx();
    chk("R11", faultCount, 2);
    // Dual pulse mode; fault inside the settle window.
    periodicSync = 1'b0; fifoLock = 1'b1; stallOn = 1'b0;
    repeat (2) @(negedge clk);
    pulseFault(1'b1);
    while (!(busy && !wrValid)) @(negedge clk);
    repeat (3) @(negedge clk);
    pulseFault(1'b0);
    waitTx();
    chk("R10", faultCount, 4);
    // Single source, zero-length window, no lock.
    dualSync = 1'b0; fifoLock = 1'b0; waitCycles = 8'd0; stallOn = 1'b1;
    repeat (2) @(negedge clk);
    pulseFault(1'b0);
    waitTx();
    repeat (3) @(negedge clk);
    chk("R10", addr1Writes, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule